// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Clear-on-Compare

The block is an 8-bit timer/counter. It advances only on single-cycle enables taken from a prescaler that runs on the system clock, so all state sits in one clock domain. A 3-bit select input chooses the enable source. It can stop the counter, pass every clock, pick one of several power-of-two division ratios, or, in one tap set, use the edges of an external count pin that the block synchronizes itself. A parameter picks between the two tap sets.

Outside PWM mode, the clear-on-compare control makes the counter return to zero on the tick after it holds the compare value. With the control off, the counter wraps through 0xFF. In PWM mode the same control bit picks the count shape. When it is clear the counter runs up to 0xFF and back down to 0x00. When it is set the counter runs up and wraps. The PWM output is high while the count is below the compare value. A one-clock strobe marks each arrival of the count at the compare value.

Top module: `prescaled_timer8`

## Requirements
- R1: While the synchronous reset `rst` is high, the counter and the match strobe are driven to 0 and the internal divider restarts. After reset is released, a divide-by-N source gives its first tick on the Nth clock edge and then one tick every N edges.
- R2: With `clk_sel` = 000 the counter holds its value and no match strobe occurs. Counting resumes from the held value when a source is selected again.
- R3: With TAP_SET = 0, `clk_sel` values 001, 010, 011, 100 and 101 give one tick every 1, 8, 64, 256 and 1024 clocks.
- R4: With TAP_SET = 1, `clk_sel` values 001 to 111 give one tick every 1, 8, 32, 64, 128, 256 and 1024 clocks.
- R5: With TAP_SET = 0, `clk_sel` = 110 counts falling edges and 111 counts rising edges of `ext_pin`. Each selected edge counts exactly once and edges of the other polarity are ignored. The count changes on the third clock edge after the pin changes.
- R6: Outside PWM mode, with `clr_on_match` = 1, a tick that finds the count equal to `cmp_val` loads 0x00. The sequence is C-1, C, 0, 1, and each value is held for the full prescale period.
- R7: Outside PWM mode, with `clr_on_match` = 0, each tick adds one and 0xFF wraps to 0x00, whatever `cmp_val` is.
- R8: In PWM mode with `clr_on_match` = 0, the counter counts up from 0x00 to 0xFF, then down to 0x00, and repeats. 0xFF is followed by 0xFE and 0x00 by 0x01.
- R9: In PWM mode with `clr_on_match` = 1, each tick adds one and 0xFF wraps to 0x00. The compare value does not clear the counter.
- R10: `match_pulse` is high for exactly the one clock that follows a tick after which the count equals `cmp_val`. It stays low for the rest of the held period.
- R11: `pwm_out` equals `pwm_mode` AND (`count` < `cmp_val`), evaluated on the present count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Tick source select |
| clr_on_match | input | 1 | Outside PWM mode: clear on compare. In PWM mode: 1 = wrap, 0 = up/down |
| pwm_mode | input | 1 | PWM mode enable |
| cmp_val | input | 8 | Compare value |
| ext_pin | input | 1 | External count pin, asynchronous |
| count | output | 8 | Counter value |
| match_pulse | output | 1 | One-clock strobe on arrival at the compare value |
| pwm_out | output | 1 | PWM output |

## Verification
Every tick source of both tap sets is swept in clear-on-compare mode with compare value 5. The bench checks count, strobe and PWM output after each clock against values worked out from the cycle count since reset. This separates the division ratios, the phase of the first tick and the hold of each value, including C and the following 0. Three more single-clock runs cover free wrap, up/down and PWM wrap. They tell apart a compare that is wrongly obeyed or wrongly ignored, the turning values at both ends, and a PWM output that compares against the wrong value. A hold-and-resume run checks the stopped source. Pin pulse trains under both edge selects, with a check two and three clocks after the pin changes, measure edge polarity, single counting and synchronizer latency.

// File: rtl/prescaled_timer8.sv
module prescaled_timer8 #(
  parameter int TAP_SET = 0,
  parameter int CW      = 8,
  parameter int DW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    clk_sel,
  input  logic          clr_on_match,
  input  logic          pwm_mode,
  input  logic [CW-1:0] cmp_val,
  input  logic          ext_pin,
  output logic [CW-1:0] count,
  output logic          match_pulse,
  output logic          pwm_out
);
  localparam logic [CW-1:0] TOP  = '1;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [DW-1:0] div;
  logic [2:0]    pin_q;
  logic          dir_up;
  logic          tick;
  logic [CW-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div   <= '0;
      pin_q <= '0;
    end else begin
      div   <= div + 1'b1;
      pin_q <= {pin_q[1:0], ext_pin};
    end
  end

  wire pin_rise = pin_q[1] & ~pin_q[2];
  wire pin_fall = ~pin_q[1] & pin_q[2];
  wire t8    = &div[2:0];
  wire t32   = &div[4:0];
  wire t64   = &div[5:0];
  wire t128  = &div[6:0];
  wire t256  = &div[7:0];
  wire t1024 = &div[9:0];

  generate
    if (TAP_SET == 0) begin : g_taps_pin
      always_comb begin
        case (clk_sel)
          3'd1:    tick = 1'b1;
          3'd2:    tick = t8;
          3'd3:    tick = t64;
          3'd4:    tick = t256;
          3'd5:    tick = t1024;
          3'd6:    tick = pin_fall;
          3'd7:    tick = pin_rise;
          default: tick = 1'b0;
        endcase
      end
    end else begin : g_taps_fine
      always_comb begin
        case (clk_sel)
          3'd1:    tick = 1'b1;
          3'd2:    tick = t8;
          3'd3:    tick = t32;
          3'd4:    tick = t64;
          3'd5:    tick = t128;
          3'd6:    tick = t256;
          3'd7:    tick = t1024;
          default: tick = 1'b0;
        endcase
      end
    end
  endgenerate

  wire updown = pwm_mode & ~clr_on_match;

  always_comb begin
    if (updown) begin
      if (dir_up) nxt = (count == TOP)  ? TOP - ONE : count + ONE;
      else        nxt = (count == ZERO) ? ONE       : count - ONE;
    end else if (!pwm_mode && clr_on_match && count == cmp_val) begin
      nxt = ZERO;
    end else begin
      nxt = count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      dir_up      <= 1'b1;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= tick && (nxt == cmp_val);
      if (tick) begin
        count <= nxt;
        if (!updown) dir_up <= 1'b1;
        else if (dir_up && count == TOP) dir_up <= 1'b0;
        else if (!dir_up && count == ZERO) dir_up <= 1'b1;
      end
    end
  end

  assign pwm_out = pwm_mode && (count < cmp_val);
endmodule

module timer8_props (
  input logic       clk,
  input logic       rst,
  input logic [2:0] clk_sel,
  input logic       clr_on_match,
  input logic       pwm_mode,
  input logic [7:0] cmp_val,
  input logic [7:0] count,
  input logic       match_pulse,
  input logic       pwm_out
);
  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0) |=> $stable(count));

  assert_clear_after_match_R6: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode && clr_on_match && $past(!pwm_mode && clr_on_match)
     && $past(count) == $past(cmp_val) && count != $past(count)) |-> count == 8'h00);

  assert_plain_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode && !clr_on_match && $past(!pwm_mode && !clr_on_match)
     && count != $past(count)) |-> count == 8'($past(count) + 8'd1));

  assert_turn_at_top_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !clr_on_match && $past(pwm_mode && !clr_on_match)
     && $past(count) == 8'hFF && count != 8'hFF) |-> count == 8'hFE);

  assert_turn_at_bottom_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !clr_on_match && $past(pwm_mode && !clr_on_match)
     && $past(count) == 8'h00 && count != 8'h00) |-> count == 8'h01);

  assert_wrap_step_R9: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && clr_on_match && $past(pwm_mode && clr_on_match)
     && count != $past(count)) |-> count == 8'($past(count) + 8'd1));

  assert_match_on_compare_R10: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> count == $past(cmp_val));

  assert_pwm_low_at_top_R11: assert property (@(posedge clk) disable iff (rst)
    (count == 8'hFF || !pwm_mode) |-> !pwm_out);
endmodule

bind prescaled_timer8 timer8_props u_props (
  .clk(clk), .rst(rst), .clk_sel(clk_sel), .clr_on_match(clr_on_match),
  .pwm_mode(pwm_mode), .cmp_val(cmp_val), .count(count),
  .match_pulse(match_pulse), .pwm_out(pwm_out)
);

// File: tb/tb_prescaled_timer8.sv
`timescale 1ns/1ps
module tb_prescaled_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'd0;
  logic       clr_on_match = 1'b0;
  logic       pwm_mode = 1'b0;
  logic [7:0] cmp_val = 8'd0;
  logic       ext_pin = 1'b0;
  logic [7:0] cnt_a, cnt_b;
  logic       m_a, m_b, p_a, p_b;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  prescaled_timer8 #(.TAP_SET(0)) dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .clr_on_match(clr_on_match),
    .pwm_mode(pwm_mode), .cmp_val(cmp_val), .ext_pin(ext_pin),
    .count(cnt_a), .match_pulse(m_a), .pwm_out(p_a));

  prescaled_timer8 #(.TAP_SET(1)) dut_b (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .clr_on_match(clr_on_match),
    .pwm_mode(pwm_mode), .cmp_val(cmp_val), .ext_pin(ext_pin),
    .count(cnt_b), .match_pulse(m_b), .pwm_out(p_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int ratio(input int which, input int s);
    if (which == 0) begin
      case (s)
        1: return 1; 2: return 8; 3: return 64; 4: return 256; 5: return 1024;
        default: return 0;
      endcase
    end
    case (s)
      1: return 1; 2: return 8; 3: return 32; 4: return 64;
      5: return 128; 6: return 256; 7: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_val(input bit clr, input bit pwm, input int cmp, input int n);
    int p;
    if (!pwm && clr) return n % (cmp + 1);
    if (pwm && !clr) begin
      p = n % 510;
      return (p <= 255) ? p : 510 - p;
    end
    return n % 256;
  endfunction

  task automatic do_reset(input logic [2:0] s, input bit clr, input bit pwm, input logic [7:0] c);
    @(negedge clk);
    rst = 1'b1; clk_sel = s; clr_on_match = clr; pwm_mode = pwm; cmp_val = c; ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cfg(input int which, input int s, input bit clr, input bit pwm,
                         input int c, input int cycles, input string req);
    int n, ev, evc;
    bit em, ep;
    logic [7:0] ac;
    logic am, ap;
    int rn;
    rn = ratio(which, s);
    do_reset(3'(s), clr, pwm, 8'(c));
    for (int e = 0; e <= cycles; e++) begin
      n  = e / rn;
      ev = exp_val(clr, pwm, c, n);
      em = (e >= 1) && (e % rn == 0) && (ev == c);
      ep = pwm && (ev < c);
      ac = which ? cnt_b : cnt_a;
      am = which ? m_b : m_a;
      ap = which ? p_b : p_a;
      if (e == 0) begin
        chk(ac == 8'd0 && am == 1'b0, "R1", "reset state count", int'(ac), 0);
      end
      chk(ac == 8'(ev), req, "count", int'(ac), ev);
      chk(am == em, "R10", "match_pulse", int'(am), int'(em));
      chk(ap == ep, "R11", "pwm_out", int'(ap), int'(ep));
      evc = ev;
      @(negedge clk);
    end
  endtask

  task automatic hold_test;
    do_reset(3'd1, 1'b0, 1'b0, 8'd200);
    repeat (10) @(negedge clk);
    chk(cnt_a == 8'd10, "R2", "count before stop", int'(cnt_a), 10);
    clk_sel = 3'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(cnt_a == 8'd10 && !m_a, "R2", "held count", int'(cnt_a), 10);
    end
    clk_sel = 3'd1;
    @(negedge clk);
    chk(cnt_a == 8'd11, "R2", "resumed count", int'(cnt_a), 11);
  endtask

  task automatic ext_test(input logic [2:0] s);
    do_reset(s, 1'b0, 1'b0, 8'd200);
    repeat (4) @(negedge clk);
    chk(cnt_a == 8'd0, "R5", "no edge yet", int'(cnt_a), 0);
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(cnt_a == 8'd5, "R5", "five pulses counted", int'(cnt_a), 5);
    ext_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_a == 8'd5, "R5", "rise latency 2", int'(cnt_a), 5);
    @(negedge clk);
    chk(cnt_a == ((s == 3'd7) ? 8'd6 : 8'd5), "R5", "rise latency 3",
        int'(cnt_a), (s == 3'd7) ? 6 : 5);
    repeat (5) @(negedge clk);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk(cnt_a == ((s == 3'd7) ? 8'd6 : 8'd5), "R5", "fall latency 2",
        int'(cnt_a), (s == 3'd7) ? 6 : 5);
    @(negedge clk);
    chk(cnt_a == 8'd6, "R5", "fall latency 3", int'(cnt_a), 6);
    repeat (6) @(negedge clk);
    chk(cnt_a == 8'd6, "R5", "no extra counts", int'(cnt_a), 6);
  endtask

  initial begin
    for (int s = 1; s <= 5; s++) run_cfg(0, s, 1'b1, 1'b0, 5, 8 * ratio(0, s) + 3, "R3");
    for (int s = 1; s <= 7; s++) run_cfg(1, s, 1'b1, 1'b0, 5, 8 * ratio(1, s) + 3, "R4");
    run_cfg(0, 2, 1'b1, 1'b0, 3, 60, "R6");
    run_cfg(0, 1, 1'b0, 1'b0, 5, 600, "R7");
    run_cfg(0, 1, 1'b0, 1'b1, 100, 1100, "R8");
    run_cfg(1, 1, 1'b1, 1'b1, 5, 600, "R9");
    hold_test();
    ext_test(3'd7);
    ext_test(3'd6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule